// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block turns a one-bit polarity command into the four gate-enable signals of an H-bridge: high and low switch of leg A, high and low switch of leg B. A high command drives current diagonally through A-high and B-low. A low command uses A-low and B-high. A high-side enable input, when low, keeps both high switches off so that the load freewheels through the low switches. A disable input, when high, turns everything off at once and has priority over every other input.

Each output turns on only after its own programmable count of clock cycles. The high sides share one delay value and the low sides share another. Every turn-off is immediate, so the delays act as dead time and either delay may be set to zero. When disable is released, the block first drives both low switches for a fixed number of cycles to recharge the high-side supplies. It then waits out the rest of a fixed hold interval, and only after that does it follow the command again.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While `dis` is high, all four outputs are low in that same cycle, whatever the other inputs are.
- R2: In run mode with `hen` high and `cmd` high, `a_hi` and `b_lo` are on and `a_lo` and `b_hi` are off.
- R3: In run mode with `hen` high and `cmd` low, `a_lo` and `b_hi` are on and `a_hi` and `b_lo` are off.
- R4: While `hen` is low, `a_hi` and `b_hi` are low in that same cycle. The low sides still follow `cmd`: `cmd` high requests only `b_lo`, and `cmd` low requests only `a_lo`.
- R5: An output first goes high exactly D+1 rising clock edges after its request appears. D is `hi_dly` for the high sides and `lo_dly` for the low sides. With D = 0 this is the next edge.
- R6: An output falls in the same cycle in which its request is withdrawn by `cmd`, `hen` or `dis`, with no clock edge in between.
- R7: If a request is withdrawn before its delay expires, that output never goes high. A later request counts its full delay again from zero.
- R8: After `dis` is sampled low following a high period, `a_lo` and `b_lo` are both high and both high sides are low for exactly REFRESH_CYC cycles, starting at the next clock edge. A new `dis` high ends this at once (R1).
- R9: Run mode begins HOLD_CYC cycles after the first refresh cycle. Until then, `cmd` and `hen` have no effect, and all outputs are low outside the refresh cycles.
- R10: `a_hi` and `a_lo` are never high together, and `b_hi` and `b_lo` are never high together.
- R11: During and right after reset all outputs are low, and the block sits in the disabled state until `dis` is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 1 | Synchronized polarity command |
| hen | input | 1 | High-side enable; low forces both high sides off |
| dis | input | 1 | Disable, active high; forces all outputs off |
| hi_dly | input | DLY_W | High-side turn-on delay in cycles |
| lo_dly | input | DLY_W | Low-side turn-on delay in cycles |
| a_hi | output | 1 | Leg A high-side gate enable |
| a_lo | output | 1 | Leg A low-side gate enable |
| b_hi | output | 1 | Leg B high-side gate enable |
| b_lo | output | 1 | Leg B low-side gate enable |

## Verification
The bound checker checks these on every clock: both legs never conduct through both switches, disable forces every output low, a low high-side enable keeps both high sides off, and the first cycle after release of disable shows the low-side refresh pattern. Only the bench scenarios can show the exact turn-on lag of each output, including zero delay. The same holds for the length of the refresh pulse and of the hold interval, for a command that toggles during the hold, and for an aborted turn-on that never asserts and is counted again from zero.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        SQ_OFF,
        SQ_REFRESH,
        SQ_HOLD,
        SQ_RUN
    } seq_state_e;

    // bit order of the packed vector: a_hi, a_lo, b_hi, b_lo
    typedef struct packed {
        logic a_hi;
        logic a_lo;
        logic b_hi;
        logic b_lo;
    } bridge_t;

    localparam int N_SW = 4;

    function automatic bridge_t bridge_map(input logic cmd, input logic hen);
        bridge_t r;
        r.a_hi = cmd & hen;
        r.b_lo = cmd;
        r.a_lo = ~cmd;
        r.b_hi = ~cmd & hen;
        return r;
    endfunction

endpackage

// File: rtl/hb_sequencer.sv
module hb_sequencer
    import hb_pkg::*;
#(
    parameter int REFRESH_CYC = 26,
    parameter int HOLD_CYC    = 45
) (
    input  logic clk,
    input  logic rst,
    input  logic dis,
    output logic run,
    output logic refresh
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] REF_LAST  = CNT_W'(REFRESH_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || dis) begin
            state <= SQ_OFF;
            cnt   <= '0;
        end else begin
            unique case (state)
                SQ_OFF: begin
                    state <= SQ_REFRESH;
                    cnt   <= '0;
                end
                SQ_REFRESH: begin
                    cnt <= cnt + CNT_W'(1);
                    if (cnt == REF_LAST) state <= SQ_HOLD;
                end
                SQ_HOLD: begin
                    cnt <= cnt + CNT_W'(1);
                    if (cnt == HOLD_LAST) state <= SQ_RUN;
                end
                SQ_RUN: state <= SQ_RUN;
                default: state <= SQ_OFF;
            endcase
        end
    end

    assign run     = (state == SQ_RUN);
    assign refresh = (state == SQ_REFRESH);

endmodule

// File: rtl/hb_turnon_delay.sv
module hb_turnon_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [DLY_W-1:0] dly,
    output logic             gate
);
    logic [DLY_W-1:0] cnt;
    logic             on_q;

    always_ff @(posedge clk) begin
        if (rst || !req) begin
            cnt  <= '0;
            on_q <= 1'b0;
        end else if (!on_q) begin
            if (cnt == dly) on_q <= 1'b1;
            else            cnt  <= cnt + DLY_W'(1);
        end
    end

    // withdrawal of the request removes the gate without waiting for a clock
    assign gate = on_q & req;

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hb_pkg::*;
#(
    parameter int DLY_W       = 8,
    parameter int REFRESH_CYC = 26,
    parameter int HOLD_CYC    = 45
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd,
    input  logic             hen,
    input  logic             dis,
    input  logic [DLY_W-1:0] hi_dly,
    input  logic [DLY_W-1:0] lo_dly,
    output logic             a_hi,
    output logic             a_lo,
    output logic             b_hi,
    output logic             b_lo
);
    logic             run;
    logic             refresh;
    bridge_t          req;
    logic [N_SW-1:0]  req_v;
    logic [N_SW-1:0]  gate_v;
    bridge_t          gate;

    hb_sequencer #(
        .REFRESH_CYC (REFRESH_CYC),
        .HOLD_CYC    (HOLD_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .dis     (dis),
        .run     (run),
        .refresh (refresh)
    );

    always_comb begin
        req = '0;
        if (run) req = bridge_map(cmd, hen);
    end

    assign req_v = req;

    for (genvar i = 0; i < N_SW; i++) begin : g_sw
        // odd bit positions of bridge_t are the high-side switches
        localparam bit IS_HIGH = (i % 2) == 1;
        hb_turnon_delay #(.DLY_W(DLY_W)) u_dly (
            .clk  (clk),
            .rst  (rst),
            .req  (req_v[i]),
            .dly  (IS_HIGH ? hi_dly : lo_dly),
            .gate (gate_v[i])
        );
    end

    assign gate = gate_v;

    assign a_hi = ~dis & gate.a_hi;
    assign b_hi = ~dis & gate.b_hi;
    assign a_lo = ~dis & (gate.a_lo | refresh);
    assign b_lo = ~dis & (gate.b_lo | refresh);

endmodule

// File: rtl/hb_checker.sv
module hb_checker (
    input logic clk,
    input logic rst,
    input logic hen,
    input logic dis,
    input logic a_hi,
    input logic a_lo,
    input logic b_hi,
    input logic b_lo
);
    p_dis_off_r1: assert property (@(posedge clk) disable iff (rst)
        dis |-> !(a_hi || a_lo || b_hi || b_lo));

    p_hen_off_r4: assert property (@(posedge clk) disable iff (rst)
        !hen |-> (!a_hi && !b_hi));

    p_leg_a_r10: assert property (@(posedge clk) disable iff (rst)
        !(a_hi && a_lo));

    p_leg_b_r10: assert property (@(posedge clk) disable iff (rst)
        !(b_hi && b_lo));

    p_refresh_start_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(dis) |=> (dis || (a_lo && b_lo && !a_hi && !b_hi)));

endmodule

bind hbridge_gate_ctrl hb_checker u_chk (
    .clk  (clk),
    .rst  (rst),
    .hen  (hen),
    .dis  (dis),
    .a_hi (a_hi),
    .a_lo (a_lo),
    .b_hi (b_hi),
    .b_lo (b_lo)
);

// File: tb/hbridge_gate_ctrl_test.sv
module hbridge_gate_ctrl_test;
    localparam int DLY_W = 8;
    localparam int REF_C = 4;
    localparam int HOLD_C = 10;

    logic clk = 1'b0;
    logic rst, cmd, hen, dis;
    logic [DLY_W-1:0] hi_dly, lo_dly;
    logic a_hi, a_lo, b_hi, b_lo;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int         c;
        logic [3:0] v;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hbridge_gate_ctrl #(
        .DLY_W(DLY_W), .REFRESH_CYC(REF_C), .HOLD_CYC(HOLD_C)
    ) uut (
        .clk(clk), .rst(rst), .cmd(cmd), .hen(hen), .dis(dis),
        .hi_dly(hi_dly), .lo_dly(lo_dly),
        .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
    );

    // vector order {a_hi, a_lo, b_hi, b_lo}
    task automatic expect_span(input int a, input int b, input logic [3:0] v, input string tag);
        for (int k = a; k <= b; k++) q.push_back('{k, v, tag});
    endtask

    task automatic wait_to(input int t);
        while (cyc != t) @(negedge clk);
    endtask

    task automatic report(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // monitor: pops expected items for the current cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst)
                report("R10 leg overlap", {a_hi & a_lo, b_hi & b_lo, 2'b00}, 4'b0000);
            while (q.size() > 0 && q[0].c <= cyc) begin
                exp_t e;
                e = q.pop_front();
                if (e.c != cyc) report({e.tag, " missed slot"}, 4'hF, 4'h0);
                else            report(e.tag, {a_hi, a_lo, b_hi, b_lo}, e.v);
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired: actual hung expected done");
        finish_run();
    end

    initial begin
        int b;
        rst = 1'b1; dis = 1'b1; cmd = 1'b1; hen = 1'b1;
        hi_dly = 8'd3; lo_dly = 8'd2;
        repeat (3) @(negedge clk);
        #1 report("R11 reset outputs", {a_hi, a_lo, b_hi, b_lo}, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        b = cyc;
        expect_span(b, b + 3, 4'b0000, "R1 disable held");
        wait_to(b + 4);

        // release: refresh, hold, then run with cmd high
        b = cyc;
        dis = 1'b0;
        expect_span(b + 1, b + 4, 4'b0101, "R8 refresh pulse");
        expect_span(b + 5, b + 10, 4'b0000, "R9 hold interval");
        expect_span(b + 11, b + 13, 4'b0000, "R5 delay pending");
        expect_span(b + 14, b + 14, 4'b0001, "R5 low side lo_dly+1");
        expect_span(b + 15, b + 20, 4'b1001, "R2 cmd high diagonal");
        wait_to(b + 6);  cmd = 1'b0;   // ignored during hold (R9)
        wait_to(b + 8);  cmd = 1'b1;
        wait_to(b + 21);

        // cmd low: immediate turn-off, delayed turn-on
        b = cyc;
        cmd = 1'b0;
        expect_span(b, b + 2, 4'b0000, "R6 immediate off");
        expect_span(b + 3, b + 3, 4'b0100, "R5 a_lo after lo_dly+1");
        expect_span(b + 4, b + 8, 4'b0110, "R3 cmd low diagonal");
        wait_to(b + 9);

        // high enable low: freewheel on low sides
        b = cyc;
        hen = 1'b0;
        expect_span(b, b + 3, 4'b0100, "R4 hen low drops b_hi");
        expect_span(b + 4, b + 6, 4'b0000, "R4 lows follow cmd");
        expect_span(b + 7, b + 9, 4'b0001, "R4 only b_lo for cmd high");
        expect_span(b + 10, b + 13, 4'b0001, "R5 a_hi pending");
        expect_span(b + 14, b + 16, 4'b1001, "R5 a_hi after hi_dly+1");
        wait_to(b + 4);  cmd = 1'b1;
        wait_to(b + 10); hen = 1'b1;
        wait_to(b + 17);

        // aborted turn-on and restart
        b = cyc;
        cmd = 1'b0;
        expect_span(b, b + 3, 4'b0000, "R7 aborted a_lo stays low");
        expect_span(b + 4, b + 4, 4'b0001, "R7 b_lo recounted");
        expect_span(b + 5, b + 7, 4'b1001, "R7 a_hi recounted");
        wait_to(b + 1);  cmd = 1'b1;
        wait_to(b + 8);

        // zero dead time
        b = cyc;
        hi_dly = 8'd0; lo_dly = 8'd0;
        expect_span(b, b, 4'b1001, "R5 steady before swap");
        expect_span(b + 1, b + 1, 4'b0000, "R6 off at swap");
        expect_span(b + 2, b + 4, 4'b0110, "R5 zero delay next edge");
        wait_to(b + 1);  cmd = 1'b0;
        wait_to(b + 5);

        // disable mid-run, then a second release
        b = cyc;
        dis = 1'b1;
        expect_span(b, b + 2, 4'b0000, "R1 disable in run");
        expect_span(b + 4, b + 7, 4'b0101, "R8 second refresh");
        expect_span(b + 8, b + 14, 4'b0000, "R9 second hold");
        expect_span(b + 15, b + 17, 4'b0110, "R3 run after hold");
        wait_to(b + 3);  dis = 1'b0;
        wait_to(b + 18);

        // disable interrupts a refresh
        b = cyc;
        dis = 1'b1;
        expect_span(b, b + 1, 4'b0000, "R1 disable again");
        expect_span(b + 3, b + 3, 4'b0101, "R8 refresh start");
        expect_span(b + 4, b + 6, 4'b0000, "R1 disable cuts refresh");
        wait_to(b + 2);  dis = 1'b0;
        wait_to(b + 4);  dis = 1'b1;
        wait_to(b + 8);

        finish_run();
    end
endmodule